// File: doc/BRIEF.md
# In-Place Permuting Frame Reorderer

The block takes a continuous serial stream of samples, grouped into frames of `LEN` samples, and sends every frame back out with its samples in a fixed permuted order. It needs only one sample RAM of `LEN` words rather than a ping-pong pair. In each cycle it reads one word and writes the new sample into the same RAM address. So the slot that a sample is read from is freed at once for the incoming sample. Because of this, the address sequence differs from frame to frame. Frame k uses the base permutation applied k times to the sample position. A small address table holds that power of the permutation and advances it by one step as each entry is used.

The address table returns to the identity only after `ORDER` frames, where `ORDER` is the order of the permutation (2 for the default bit reversal). For that reason a frame-start pulse may only repeat at a whole multiple of `LEN*ORDER` samples. The block measures the spacing of successive frame-start pulses and raises an error flag when that spacing is wrong. The permutation is selected by an elaboration parameter: bit reversal, perfect shuffle or identity. The frame-start pulse comes one cycle ahead of a frame's first sample. Output data trails the input by exactly one frame plus one cycle.

Top module: `inplace_reorder`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `dout`, `sync_out` and `sync_err` are all zero.
- R2: Until the first `sync_in` pulse after reset, `dout` stays at zero and `din` has no effect on any output.
- R3: When `sync_in` is high in cycle t, sample position 0 of a frame arrives in cycle t+1 and positions continue one per cycle. If a sample at position i (4-bit position with the default `AW=4`) arrives in cycle c, then `dout` in cycle c+1 carries the sample that sat at position P(i) of the previous frame. P is the 4-bit bit reversal by default (position b3b2b1b0 maps to b0b1b2b3).
- R4: Frames follow one another back to back without further `sync_in` pulses, and the mapping of R3 holds across every frame boundary.
- R5: A `sync_in` pulse that comes a whole multiple of `LEN*ORDER` samples after the previous pulse (32 with the defaults) leaves the output stream uninterrupted. Such a pulse coincides with the last sample of the period.
- R6: `sync_out` is high in the cycle after a `sync_in` pulse, which is one cycle before the first reordered sample appears on `dout`. It is high at no other time.
- R7: No `sync_out` is produced for the first `sync_in` after reset unless a complete frame has already been stored.
- R8: `sync_err` is high for one cycle, the cycle after a `sync_in` pulse, whenever the pulse comes while the stream is running at a spacing from the previous pulse that is not a whole multiple of `LEN*ORDER` samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Frame-start pulse, one cycle ahead of position 0 |
| din | input | DW | Input sample, one per cycle |
| sync_out | output | 1 | Output frame-start pulse, one cycle ahead of reordered position 0 |
| dout | output | DW | Reordered sample, registered |
| sync_err | output | 1 | Pulses after a frame-start pulse at an illegal spacing |

## Verification
Each sample fed in cycle c produces an output in cycle c+1, and the value is drawn from the preceding frame. `sync_out` and `sync_err` both answer a `sync_in` pulse one cycle later. The bench's behavioural model works out, at each rising edge, the value every output must carry once that edge has passed: it stores whole frames and indexes the previous one by the bit-reversed position. The bench compares against those values at the following falling edge, so every result is checked in exactly the cycle it is due. After the deliberately misplaced pulse the data are no longer predictable, so from then on only the two flags are compared.

// File: rtl/inplace_pkg.sv
package inplace_pkg;

  // Permutation variants selectable at elaboration time
  localparam int KIND_BITREV  = 0;
  localparam int KIND_SHUFFLE = 1;
  localparam int KIND_IDENT   = 2;

  // Image of position idx under the chosen permutation of aw-bit indices
  function automatic int perm_apply(int kind, int aw, int idx);
    int r;
    r = 0;
    if (kind == KIND_BITREV) begin
      for (int b = 0; b < aw; b++)
        if (((idx >> b) & 1) != 0) r = r | (1 << (aw - 1 - b));
    end else if (kind == KIND_SHUFFLE) begin
      r = ((idx << 1) | (idx >> (aw - 1))) & ((1 << aw) - 1);
    end else begin
      r = idx;
    end
    return r;
  endfunction

  function automatic int gcd_int(int a, int b);
    int x, y, t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  // Order of the permutation: lcm of all its cycle lengths
  function automatic int perm_order(int kind, int aw);
    int ord, j, c;
    ord = 1;
    for (int i = 0; i < (1 << aw); i++) begin
      j = perm_apply(kind, aw, i);
      c = 1;
      while (j != i) begin
        j = perm_apply(kind, aw, j);
        c++;
      end
      ord = (ord / gcd_int(ord, c)) * c;
    end
    return ord;
  endfunction

endpackage

// File: rtl/inplace_addr_table.sv
// Holds P^k(i) for every position i; entry i is advanced to P^(k+1)(i)
// in the cycle it is used, so the table needs no second copy.
module inplace_addr_table
  import inplace_pkg::*;
#(
  parameter int AW   = 4,
  parameter int KIND = KIND_BITREV
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [AW-1:0] idx,
  output logic [AW-1:0] addr
);
  localparam int LEN = 1 << AW;

  logic [AW-1:0] base [LEN];
  logic [AW-1:0] tbl  [LEN];

  for (genvar g = 0; g < LEN; g++) begin : g_base
    localparam logic [AW-1:0] IMG = AW'(perm_apply(KIND, AW, g));
    assign base[g] = IMG;
  end

  assign addr = tbl[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LEN; i++) tbl[i] <= AW'(i);
    end else if (adv) begin
      tbl[idx] <= base[addr];
    end
  end

endmodule

// File: rtl/inplace_frame_seq.sv
// Position and frame-in-period counters, start tracking and sync checks.
module inplace_frame_seq #(
  parameter int AW    = 4,
  parameter int ORDER = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_i,
  output logic          act_o,
  output logic [AW-1:0] pos_o,
  output logic          so_o,
  output logic          err_o
);
  localparam int LEN = 1 << AW;
  localparam int FW  = (ORDER > 1) ? $clog2(ORDER) : 1;

  logic          act_q, filled_q, so_q, err_q;
  logic [AW-1:0] pos_q;
  logic [FW-1:0] fr_q;
  logic          last_smp, last_per;

  assign last_smp = (pos_q == AW'(LEN - 1));
  assign last_per = last_smp && (fr_q == FW'(ORDER - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      filled_q <= 1'b0;
      so_q     <= 1'b0;
      err_q    <= 1'b0;
      pos_q    <= '0;
      fr_q     <= '0;
    end else begin
      so_q  <= sync_i && act_q && (filled_q || last_smp);
      err_q <= sync_i && act_q && !last_per;
      if (act_q) begin
        pos_q <= pos_q + 1'b1;
        if (last_smp) begin
          filled_q <= 1'b1;
          fr_q     <= (fr_q == FW'(ORDER - 1)) ? '0 : fr_q + 1'b1;
        end
      end
      if (sync_i) begin
        act_q <= 1'b1;
        pos_q <= '0;
        fr_q  <= '0;
      end
    end
  end

  assign act_o = act_q;
  assign pos_o = pos_q;
  assign so_o  = so_q;
  assign err_o = err_q;

endmodule

// File: rtl/inplace_sample_ram.sv
// Single-port read-first RAM with registered read data.
module inplace_sample_ram #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (en) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_q <= '0;
    else if (en) rd_q <= mem[addr];
  end

  assign rdata = rd_q;

endmodule

// File: rtl/inplace_reorder.sv
module inplace_reorder
  import inplace_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 4,
  parameter int KIND = KIND_BITREV
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_in,
  input  logic [DW-1:0] din,
  output logic          sync_out,
  output logic [DW-1:0] dout,
  output logic          sync_err
);
  localparam int ORDER = perm_order(KIND, AW);

  logic          act;
  logic [AW-1:0] pos;
  logic [AW-1:0] addr;

  inplace_frame_seq #(.AW(AW), .ORDER(ORDER)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .sync_i (sync_in),
    .act_o  (act),
    .pos_o  (pos),
    .so_o   (sync_out),
    .err_o  (sync_err)
  );

  inplace_addr_table #(.AW(AW), .KIND(KIND)) u_tbl (
    .clk  (clk),
    .rst  (rst),
    .adv  (act),
    .idx  (pos),
    .addr (addr)
  );

  inplace_sample_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .en    (act),
    .addr  (addr),
    .wdata (din),
    .rdata (dout)
  );

endmodule

// File: rtl/inplace_reorder_chk.sv
module inplace_reorder_chk #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          sync_in,
  input logic          act,
  input logic [AW-1:0] pos,
  input logic [DW-1:0] dout,
  input logic          sync_out,
  input logic          sync_err
);
  localparam int LEN = 1 << AW;

  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (dout == '0 && !sync_out && !sync_err));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !act |=> $stable(dout));

  // R6
  so_after_sync_chk: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> $past(sync_in));

  // R7
  first_sync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(act) |-> !sync_out);

  // R8
  midframe_err_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_in && act && pos != AW'(LEN - 1)) |=> sync_err);

  // R8
  err_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
    sync_err |-> ($past(sync_in) && $past(act)));

endmodule

bind inplace_reorder inplace_reorder_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sync_in  (sync_in),
  .act      (act),
  .pos      (pos),
  .dout     (dout),
  .sync_out (sync_out),
  .sync_err (sync_err)
);

// File: tb/sim_inplace_reorder.sv
`timescale 1ns/1ps
module sim_inplace_reorder;
  localparam int DW  = 16;
  localparam int AW  = 4;
  localparam int LEN = 16;
  localparam int PER = 32;   // LEN * order of 4-bit bit reversal

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sync_in = 1'b0;
  logic [DW-1:0] din = '0;
  logic          sync_out;
  logic [DW-1:0] dout;
  logic          sync_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  inplace_reorder #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .sync_in(sync_in), .din(din),
    .sync_out(sync_out), .dout(dout), .sync_err(sync_err)
  );

  function automatic int brev(int i);
    return ((i & 1) << 3) | ((i & 2) << 1) | ((i & 4) >> 1) | ((i & 8) >> 3);
  endfunction

  // reference model state
  int  cur [LEN];
  int  prev [LEN];
  int  m_pos = 0, m_since = 0, m_fdone = 0;
  bit  m_run = 0, m_glitch = 0, m_resync = 0;
  bit  e_so = 0, e_err = 0, e_chk = 0;
  int  e_d = 0;
  string so_tag = "R6", d_tag = "R3";

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_since = 0; m_fdone = 0;
      m_run = 0; m_glitch = 0; m_resync = 0;
      e_so = 0; e_err = 0; e_chk = 0; e_d = 0;
    end else begin
      so_tag = (sync_in && !m_run) ? "R7" : "R6";
      e_so  = sync_in && m_run && (m_fdone >= 1 || m_pos == LEN - 1);
      e_err = sync_in && m_run && (((m_since + 1) % PER) != 0);
      e_chk = 0;
      if (m_run) begin
        cur[m_pos] = int'(din);
        if (m_fdone >= 1 && !m_glitch) begin
          e_d   = prev[brev(m_pos)];
          e_chk = 1;
          d_tag = m_resync ? "R5" : (m_fdone >= 2 ? "R4" : "R3");
        end
        m_pos++;
        m_since++;
        if (m_pos == LEN) begin
          for (int k = 0; k < LEN; k++) prev[k] = cur[k];
          m_pos = 0;
          m_fdone++;
          m_resync = 0;
        end
      end
      if (sync_in) begin
        if (e_err) m_glitch = 1;
        if (m_run && !e_err) m_resync = 1;
        m_pos = 0;
        m_since = 0;
        m_run = 1;
      end
    end
  end

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(so_tag, int'(sync_out), int'(e_so));
      check("R8", int'(sync_err), int'(e_err));
      if (!m_run) check("R2", int'(dout), 0);
      else if (e_chk) check(d_tag, int'(dout), e_d);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(dout), 0);
    check("R1", int'(sync_out), 0);
    check("R1", int'(sync_err), 0);
    rst = 1'b0;
    // idle samples before any sync must not reach the output (R2)
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      din = DW'(16'hA5A5 ^ (n * 16'h1111));
    end
    @(negedge clk);
    sync_in = 1'b1;
    din = 16'hFFFF;
    // stream; legal resyncs at 32 and 96, illegal one at 133
    for (int s = 1; s <= 140; s++) begin
      @(negedge clk);
      din = {8'(s), ~8'(s)};
      sync_in = (s == 32 || s == 96 || s == 133);
    end
    @(negedge clk);
    sync_in = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule